// File: doc/BRIEF.md
# Stereo Attenuation, Routing and Silence-Detect Stage

This stage takes one signed 18-bit left/right sample pair per frame and returns the processed pair one clock later. Each channel is scaled by its own 8-bit attenuation code on a 256-step linear law. Code 0 is silence and code 255 is exact unity gain. A code written with the load bit low leaves the applied gain unchanged. A common-gain control lets the left code drive both channels.

The scaled pair then passes through a routing matrix. Each output independently takes silence, the left signal, the right signal or their halved sum. After routing, an output-disable control forces both outputs to bipolar zero. A mute request, from a control bit or an active-low pin, ramps a shared gain ceiling down one code per sample and back up on release. A silence watcher counts bit-clock ticks while the incoming pair stays exactly zero. When the count reaches the limit and detection is enabled, it pulls an open-drain-style flag low.

Top module: `stereo_post_stage`

## Requirements
- R1: Each channel output equals floor(sample * y / 256), where y is the code for codes 0 to 254 and y = 256 for code 255. The applied codes reset to 255.
- R2: A write on a channel's code port with `atten_commit` low does not change that channel's gain. A write with `atten_commit` high applies the written code to samples strobed after that edge.
- R3: While `atten_common` is high, the applied left code scales both channels and the right code has no effect on the outputs.
- R4: `route_sel[3:2]` picks the left output and `route_sel[1:0]` picks the right output. The encoding is 00 silence, 01 right, 10 left, 11 half-sum. So 4'b1001 is straight stereo, 4'b0110 swaps the channels and 4'b1111 is mono on both outputs.
- R5: The half-sum is formed at 19 bits and shifted right arithmetically by one. Full-scale inputs of the same sign therefore return full scale with no wrap.
- R6: A sample strobed while `out_disable` is high produces 0 on both outputs.
- R7: Mute is active when `mute_reg` is high or `mute_n` is low. The gain ceiling starts at 255 and moves one code per strobed sample: toward 0 while mute is active, toward 255 otherwise. Each sample uses the ceiling value from before its own step, and the applied code is the minimum of the channel code and the ceiling.
- R8: After a strobed all-zero pair, `zero_pull_low` goes high once `ZERO_TICKS` (default 65,536) `bit_tick` cycles have been counted, provided `zero_det_en` is high. Further all-zero samples keep it high, and `zero_det_en` low releases it combinationally.
- R9: A strobed pair with any nonzero sample restarts the count, and `zero_pull_low` is low from the next clock.
- R10: `out_valid` is a one-cycle pulse in the cycle after each strobe. The outputs hold between strobes. After reset, `out_valid`, both outputs and `zero_pull_low` are 0.
- R11: When a committed code write and a sample strobe fall on the same edge, that sample uses the previously applied code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample pair strobe |
| smp_left | input | 18 | Left input sample, two's complement |
| smp_right | input | 18 | Right input sample, two's complement |
| bit_tick | input | 1 | One pulse per serial bit clock, used for silence counting |
| atten_wr_left | input | 1 | Write the left attenuation code |
| atten_wr_right | input | 1 | Write the right attenuation code |
| atten_code | input | 8 | Attenuation code to write |
| atten_commit | input | 1 | Load bit: apply the written code |
| atten_common | input | 1 | Left code scales both channels |
| route_sel | input | 4 | Output routing selection |
| mute_reg | input | 1 | Mute request from the control register |
| mute_n | input | 1 | Active-low mute pin |
| out_disable | input | 1 | Force both outputs to bipolar zero |
| zero_det_en | input | 1 | Enable the silence flag |
| out_valid | output | 1 | Output pair valid pulse |
| out_left | output | 18 | Left output sample |
| out_right | output | 18 | Right output sample |
| zero_pull_low | output | 1 | High when the silence flag should be driven low; low means released |

## Verification
A committed code write can land on the same edge as a sample strobe, and so can a change of mute request. The bench provokes the first by driving a commit and a strobe in one cycle. It expects the old gain on that sample and the new gain on the following one. The silence flag and a nonzero sample also meet: a nonzero pair strobed while the flag is pulled must come out scaled normally, and the flag must be released from the next clock.

// File: rtl/stps_pkg.sv
package stps_pkg;
  localparam int SAMPLE_W = 18;
  localparam int CODE_W   = 8;

  typedef enum logic [1:0] {
    SRC_SILENT = 2'b00,
    SRC_RIGHT  = 2'b01,
    SRC_LEFT   = 2'b10,
    SRC_HALF   = 2'b11
  } route_src_e;
endpackage

// File: rtl/stps_coef_bank.sv
module stps_coef_bank #(
  parameter int C = stps_pkg::CODE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_left,
  input  logic         wr_right,
  input  logic [C-1:0] code,
  input  logic         commit,
  input  logic         common,
  input  logic         strobe,
  input  logic         mute_req,
  output logic [C-1:0] eff_left,
  output logic [C-1:0] eff_right,
  output logic [C-1:0] ceiling
);
  localparam logic [C-1:0] FULL = '1;

  logic [C-1:0] applied_q [2];
  logic [1:0]   wr_v;
  logic [C-1:0] ceil_q;

  assign wr_v = {wr_right, wr_left};

  function automatic logic [C-1:0] lower_of(input logic [C-1:0] a, input logic [C-1:0] b);
    return (a < b) ? a : b;
  endfunction

  for (genvar g = 0; g < 2; g++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rst_n)
        applied_q[g] <= FULL;
      else if (wr_v[g] && commit)
        applied_q[g] <= code;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ceil_q <= FULL;
    else if (strobe) begin
      if (mute_req && ceil_q != '0)
        ceil_q <= ceil_q - 1'b1;
      else if (!mute_req && ceil_q != FULL)
        ceil_q <= ceil_q + 1'b1;
    end
  end

  assign ceiling   = ceil_q;
  assign eff_left  = lower_of(applied_q[0], ceil_q);
  assign eff_right = lower_of(common ? applied_q[0] : applied_q[1], ceil_q);
endmodule

// File: rtl/stps_gain.sv
module stps_gain #(
  parameter int W = stps_pkg::SAMPLE_W,
  parameter int C = stps_pkg::CODE_W
) (
  input  logic signed [W-1:0] sample,
  input  logic        [C-1:0] code,
  output logic signed [W-1:0] scaled
);
  function automatic logic [C:0] code_weight(input logic [C-1:0] c);
    return (c == {C{1'b1}}) ? (C+1)'(1 << C) : {1'b0, c};
  endfunction

  function automatic logic signed [W-1:0] scale(input logic signed [W-1:0] s,
                                                input logic [C-1:0] c);
    logic signed [W+C+1:0] prod;
    prod = s * $signed({1'b0, code_weight(c)});
    return prod[W+C-1:C];
  endfunction

  assign scaled = scale(sample, code);
endmodule

// File: rtl/stps_route.sv
module stps_route
  import stps_pkg::*;
#(
  parameter int W = stps_pkg::SAMPLE_W
) (
  input  logic signed [W-1:0] in_left,
  input  logic signed [W-1:0] in_right,
  input  logic        [3:0]   sel,
  output logic signed [W-1:0] out_left,
  output logic signed [W-1:0] out_right
);
  logic signed [W-1:0] half;
  logic signed [W-1:0] pick [2];

  function automatic logic signed [W-1:0] half_sum(input logic signed [W-1:0] a,
                                                   input logic signed [W-1:0] b);
    logic signed [W:0] s;
    s = {a[W-1], a} + {b[W-1], b};
    return s[W:1];
  endfunction

  assign half = half_sum(in_left, in_right);

  for (genvar g = 0; g < 2; g++) begin : g_out
    route_src_e src;
    assign src = route_src_e'(sel[3-2*g -: 2]);
    always_comb begin
      unique case (src)
        SRC_SILENT: pick[g] = '0;
        SRC_RIGHT:  pick[g] = in_right;
        SRC_LEFT:   pick[g] = in_left;
        default:    pick[g] = half;
      endcase
    end
  end

  assign out_left  = pick[0];
  assign out_right = pick[1];
endmodule

// File: rtl/stps_zero_watch.sv
module stps_zero_watch #(
  parameter int LIMIT = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic in_zero,
  input  logic bit_tick,
  input  logic enable,
  output logic pull_low
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] run_q;
  logic          armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (strobe)
        armed_q <= in_zero;
      if (strobe && !in_zero)
        run_q <= '0;
      else if (armed_q && bit_tick && run_q != TOP)
        run_q <= run_q + 1'b1;
    end
  end

  assign pull_low = enable && (run_q == TOP);
endmodule

// File: rtl/stereo_post_stage.sv
module stereo_post_stage #(
  parameter int SAMPLE_W   = stps_pkg::SAMPLE_W,
  parameter int CODE_W     = stps_pkg::CODE_W,
  parameter int ZERO_TICKS = 65536
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp_left,
  input  logic signed [SAMPLE_W-1:0] smp_right,
  input  logic                       bit_tick,
  input  logic                       atten_wr_left,
  input  logic                       atten_wr_right,
  input  logic        [CODE_W-1:0]   atten_code,
  input  logic                       atten_commit,
  input  logic                       atten_common,
  input  logic        [3:0]          route_sel,
  input  logic                       mute_reg,
  input  logic                       mute_n,
  input  logic                       out_disable,
  input  logic                       zero_det_en,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_left,
  output logic signed [SAMPLE_W-1:0] out_right,
  output logic                       zero_pull_low
);
  logic [CODE_W-1:0]          eff_code [2];
  logic [CODE_W-1:0]          mute_lvl_w;
  logic signed [SAMPLE_W-1:0] raw [2];
  logic signed [SAMPLE_W-1:0] scaled [2];
  logic signed [SAMPLE_W-1:0] routed_l, routed_r;
  logic                       in_zero, force_mid, mute_req;

  assign raw[0]   = smp_left;
  assign raw[1]   = smp_right;
  assign in_zero  = (smp_left == '0) && (smp_right == '0);
  assign mute_req = mute_reg || !mute_n;

  stps_coef_bank #(.C(CODE_W)) coef_i (
    .clk(clk), .rst_n(rst_n),
    .wr_left(atten_wr_left), .wr_right(atten_wr_right),
    .code(atten_code), .commit(atten_commit), .common(atten_common),
    .strobe(smp_valid), .mute_req(mute_req),
    .eff_left(eff_code[0]), .eff_right(eff_code[1]), .ceiling(mute_lvl_w)
  );

  for (genvar g = 0; g < 2; g++) begin : g_gain
    stps_gain #(.W(SAMPLE_W), .C(CODE_W)) gain_i (
      .sample(raw[g]), .code(eff_code[g]), .scaled(scaled[g])
    );
  end

  stps_route #(.W(SAMPLE_W)) route_i (
    .in_left(scaled[0]), .in_right(scaled[1]), .sel(route_sel),
    .out_left(routed_l), .out_right(routed_r)
  );

  stps_zero_watch #(.LIMIT(ZERO_TICKS)) zero_i (
    .clk(clk), .rst_n(rst_n), .strobe(smp_valid), .in_zero(in_zero),
    .bit_tick(bit_tick), .enable(zero_det_en), .pull_low(zero_pull_low)
  );

  assign force_mid = out_disable || (zero_pull_low && in_zero);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      out_valid <= smp_valid;
      if (smp_valid) begin
        out_left  <= force_mid ? '0 : routed_l;
        out_right <= force_mid ? '0 : routed_r;
      end
    end
  end
endmodule

// File: rtl/stps_checker.sv
module stps_checker #(
  parameter int W = 18,
  parameter int C = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_valid,
  input logic                out_disable,
  input logic signed [W-1:0] smp_left,
  input logic signed [W-1:0] smp_right,
  input logic                out_valid,
  input logic signed [W-1:0] out_left,
  input logic signed [W-1:0] out_right,
  input logic                zero_pull_low,
  input logic        [C-1:0] mute_lvl
);
  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> out_valid);

  assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> (!out_valid && $stable(out_left) && $stable(out_right)));

  assert_disable_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && out_disable) |=> (out_left == '0 && out_right == '0));

  assert_ramp_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> (({1'b0, mute_lvl} == {1'b0, $past(mute_lvl)} + 1'b1) ||
                   ({1'b0, mute_lvl} + 1'b1 == {1'b0, $past(mute_lvl)}) ||
                   (mute_lvl == $past(mute_lvl))));

  assert_ramp_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(mute_lvl));

  assert_flag_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (smp_left != '0 || smp_right != '0)) |=> !zero_pull_low);
endmodule

bind stereo_post_stage stps_checker #(.W(SAMPLE_W), .C(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .out_disable(out_disable),
  .smp_left(smp_left), .smp_right(smp_right), .out_valid(out_valid),
  .out_left(out_left), .out_right(out_right), .zero_pull_low(zero_pull_low),
  .mute_lvl(mute_lvl_w)
);

// File: tb/stereo_post_stage_tb_top.sv
module stereo_post_stage_tb_top;
  localparam int W = 18;
  localparam int WATCH_LIMIT = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [W-1:0] smp_left = '0, smp_right = '0;
  logic bit_tick = 1'b0;
  logic atten_wr_left = 1'b0, atten_wr_right = 1'b0, atten_commit = 1'b0, atten_common = 1'b0;
  logic [7:0] atten_code = '0;
  logic [3:0] route_sel = 4'b1001;
  logic mute_reg = 1'b0, mute_n = 1'b1, out_disable = 1'b0, zero_det_en = 1'b0;
  logic out_valid, zero_pull_low;
  logic signed [W-1:0] out_left, out_right;

  always #5 clk = ~clk;

  stereo_post_stage dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_left(smp_left),
    .smp_right(smp_right), .bit_tick(bit_tick), .atten_wr_left(atten_wr_left),
    .atten_wr_right(atten_wr_right), .atten_code(atten_code),
    .atten_commit(atten_commit), .atten_common(atten_common),
    .route_sel(route_sel), .mute_reg(mute_reg), .mute_n(mute_n),
    .out_disable(out_disable), .zero_det_en(zero_det_en), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right), .zero_pull_low(zero_pull_low)
  );

  typedef struct { int l; int r; string tag; } exp_t;
  exp_t sb_q[$];
  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // bench-side model state
  int m_code_l = 255, m_code_r = 255, m_ceil = 255;

  function automatic int bm_gain(int s, int c);
    int y;
    longint p;
    y = (c == 255) ? 256 : c;
    p = longint'(s) * longint'(y);
    return int'(p >>> 8);
  endfunction

  function automatic int bm_pick(int sel, int a, int b);
    case (sel)
      0: return 0;
      1: return b;
      2: return a;
      default: return (a + b) >>> 1;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // push the expected pair for a strobe taken with the current inputs
  task automatic predict(int l, int r, string tag);
    int cl, cr, gl, gr, ol, orr;
    bit muted;
    exp_t e;
    cl = (m_code_l < m_ceil) ? m_code_l : m_ceil;
    cr = atten_common ? m_code_l : m_code_r;
    cr = (cr < m_ceil) ? cr : m_ceil;
    gl = bm_gain(l, cl);
    gr = bm_gain(r, cr);
    ol = bm_pick(int'(route_sel[3:2]), gl, gr);
    orr = bm_pick(int'(route_sel[1:0]), gl, gr);
    if (out_disable) begin ol = 0; orr = 0; end
    e.l = ol; e.r = orr; e.tag = tag;
    sb_q.push_back(e);
    muted = mute_reg || !mute_n;
    if (muted && m_ceil > 0) m_ceil--;
    else if (!muted && m_ceil < 255) m_ceil++;
  endtask

  task automatic send(int l, int r, string tag);
    @(negedge clk);
    smp_left = W'(l); smp_right = W'(r); smp_valid = 1'b1;
    predict(l, r, tag);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic write_code(bit right, int code, bit commit);
    @(negedge clk);
    atten_wr_left = !right; atten_wr_right = right;
    atten_code = 8'(code); atten_commit = commit;
    if (commit) begin
      if (right) m_code_r = code; else m_code_l = code;
    end
    @(negedge clk);
    atten_wr_left = 1'b0; atten_wr_right = 1'b0; atten_commit = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 unexpected out_valid actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " left"}, int'(out_left), e.l);
        check({e.tag, " right"}, int'(out_right), e.r);
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCH_LIMIT) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCH_LIMIT);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 reset valid", int'(out_valid), 0);
    check("R10 reset left", int'(out_left), 0);
    check("R10 reset right", int'(out_right), 0);
    check("R10 reset flag", int'(zero_pull_low), 0);

    // R1 unity at reset code 255, sign corners
    send(1000, -2000, "R1 unity");
    send(131071, -131072, "R1 full scale");
    write_code(0, 0, 1);
    write_code(1, 1, 1);
    send(50000, -1, "R1 silence and code 1");
    write_code(0, 128, 1);
    write_code(1, 254, 1);
    send(-777, 131071, "R1 mid codes");

    // R2 write without commit leaves gain
    write_code(0, 10, 0);
    write_code(1, 20, 0);
    send(4096, 4096, "R2 staged only");
    write_code(0, 64, 1);
    send(4096, 4096, "R2 committed");

    // R11 commit coincident with strobe
    @(negedge clk);
    atten_wr_left = 1'b1; atten_code = 8'd200; atten_commit = 1'b1;
    smp_left = 18'sd10000; smp_right = 18'sd0; smp_valid = 1'b1;
    predict(10000, 0, "R11 old gain on same edge");
    m_code_l = 200;
    @(negedge clk);
    atten_wr_left = 1'b0; atten_commit = 1'b0; smp_valid = 1'b0;
    send(10000, 0, "R11 new gain next sample");

    // R3 common gain
    atten_common = 1'b1;
    send(3000, -3000, "R3 left code both");
    write_code(1, 0, 1);
    send(3000, -3000, "R3 right code ignored");
    atten_common = 1'b0;
    send(3000, -3000, "R3 separate again");
    write_code(0, 255, 1);
    write_code(1, 255, 1);

    // R4 routing
    route_sel = 4'b0110; send(111, -222, "R4 swap");
    route_sel = 4'b1111; send(111, -222, "R4 mono");
    route_sel = 4'b0001; send(111, -222, "R4 silence/right");
    route_sel = 4'b1110; send(111, -222, "R4 half/left");
    // R5 no overflow
    route_sel = 4'b1111;
    send(131071, 131071, "R5 positive full");
    send(-131072, -131072, "R5 negative full");
    send(-131072, 131071, "R5 mixed sign");
    route_sel = 4'b1001;

    // R6 disable
    out_disable = 1'b1;
    send(5000, -5000, "R6 disabled");
    out_disable = 1'b0;
    send(5000, -5000, "R6 re-enabled");

    // R7 mute ramp by register, then by pin
    mute_reg = 1'b1;
    for (int i = 0; i < 260; i++) send(100000, -100000, "R7 ramp down");
    mute_reg = 1'b0;
    for (int i = 0; i < 5; i++) send(100000, -100000, "R7 ramp up");
    mute_n = 1'b0;
    for (int i = 0; i < 3; i++) send(100000, -100000, "R7 pin mute");
    mute_n = 1'b1;
    for (int i = 0; i < 260; i++) send(100000, -100000, "R7 recover");

    // R8 silence detection
    zero_det_en = 1'b1;
    send(0, 0, "R8 zero sample");
    @(negedge clk);
    bit_tick = 1'b1;
    repeat (65535) @(negedge clk);
    check("R8 flag before limit", int'(zero_pull_low), 0);
    @(negedge clk);
    bit_tick = 1'b0;
    check("R8 flag at limit", int'(zero_pull_low), 1);
    zero_det_en = 1'b0; #1;
    check("R8 enable low releases", int'(zero_pull_low), 0);
    zero_det_en = 1'b1; #1;
    check("R8 enable high again", int'(zero_pull_low), 1);
    send(0, 0, "R8 zero keeps flag");
    check("R8 flag held", int'(zero_pull_low), 1);

    // R9 nonzero releases, output normal
    send(0, 9, "R9 nonzero sample");
    check("R9 flag released", int'(zero_pull_low), 0);

    repeat (4) @(negedge clk);
    check("R10 queue drained", sb_q.size(), 0);
    finish_run();
  end
endmodule